// File: doc/BRIEF.md
# Serial Volume-Control Register Interface

This block is the digital front end of a two-channel stepped audio attenuator. A host sends control words over three wires: a frame-enable line, a serial clock and a data line. The block runs on a fast system clock. It synchronises and oversamples all three lines. While the enable line is high, it assembles the bits of a frame. It acts on the frame only when the enable line falls. A frame is kept when it has exactly twenty bits and its leading eight-bit address equals the code chosen by a strap input. In that case the two six-bit channel codes it carries are stored.

Each stored code drives two one-hot switch-select buses. One bus controls a coarse ladder in 10 dB steps, the other a fine ladder in 2 dB steps. A separate cut line is raised for the full-cut position. The left and right channels are decoded on their own, so a host sets balance by sending two different codes. A mute output stays high from reset until the first frame is accepted. This covers the time after power-up when the ladder switches hold no known setting.

Top module: `volctl_serial_if`

## Requirements
- R1: Data bits are taken on each rising edge of the serial clock while the enable line is high, least significant bit first. Bits 0..7 of the frame form the address, bits 8..13 the left code and bits 14..19 the right code.
- R2: With the strap input high, only address 88 is accepted. With the strap low, only address 89 is accepted. A frame with any other address leaves every output unchanged.
- R3: Stored settings and outputs change only in response to a falling edge of the enable line. Outputs do not move while a frame is still being clocked in.
- R4: A frame whose bit count at the falling edge of the enable line is not exactly 20 (shorter or longer) is discarded, and the previous settings are kept.
- R5: For a code c in 0..34, the coarse select has only bit c/5 set (c/5 × 10 dB of loss), the fine select has only bit c mod 5 set (c mod 5 × 2 dB of loss), and the cut line is low.
- R6: For a code of 35 or above, all coarse and fine selects are low and the cut line is high.
- R7: The left and right channels are decoded independently from their own code fields.
- R8: Mute is high from reset and stays high through rejected frames. It goes low on the first accepted frame and never rises again until the next reset.
- R9: After reset, both channels are at the full-cut position.
- R10: Serial clock edges that occur while the enable line is low neither shift data nor count toward the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs | input | 1 | Frame enable; high while a frame is shifted, falling edge commits |
| ser_clk | input | 1 | Serial bit clock; data taken on its rising edge |
| ser_dat | input | 1 | Serial data, LSB first |
| addr_sel | input | 1 | Strap: high selects address 88, low selects 89 |
| l_coarse | output | COARSE_N (7) | Left coarse 10 dB ladder one-hot select |
| l_fine | output | FINE_N (5) | Left fine 2 dB ladder one-hot select |
| l_cut | output | 1 | Left full-cut position |
| r_coarse | output | COARSE_N (7) | Right coarse 10 dB ladder one-hot select |
| r_fine | output | FINE_N (5) | Right fine 2 dB ladder one-hot select |
| r_cut | output | 1 | Right full-cut position |
| mute | output | 1 | High until the first accepted frame |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 6-bit codes, seven coarse and five fine taps, and a two-stage synchroniser. With these values the whole code space is reachable, including the 34/35 boundary between the deepest step and cut, and the unused codes up to 63. The serial phases are held for a few system clocks. As a result, synchroniser latency, commit timing and the cycle in which the enable line falls are all compared cycle by cycle against the model. This covers frames one bit short and one bit long, both strap settings, and clock edges outside a frame.

// File: rtl/volctl_pkg.sv
package volctl_pkg;

   // one sample of the three serial control lines
   typedef struct packed {
      logic cs;
      logic sck;
      logic sd;
   } vc_pins_t;

   localparam int unsigned VC_ADDR_W   = 8;
   localparam int unsigned VC_CODE_W   = 6;
   localparam int unsigned VC_COARSE_N = 7;
   localparam int unsigned VC_FINE_N   = 5;

endpackage

// File: rtl/volctl_sync.sv
module volctl_sync
   import volctl_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  vc_pins_t pins_i,
   output vc_pins_t pins_o,
   output logic     cs_fall,
   output logic     sck_rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("volctl_sync: STAGES must be at least 2");
      end
   endgenerate

   vc_pins_t [STAGES-1:0] stg;
   vc_pins_t              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg  <= '0;
         prev <= '0;
      end else begin
         stg  <= {stg[STAGES-2:0], pins_i};
         prev <= stg[STAGES-1];
      end
   end

   assign pins_o   = stg[STAGES-1];
   assign cs_fall  = prev.cs & ~pins_o.cs;
   assign sck_rise = pins_o.sck & ~prev.sck;

endmodule

// File: rtl/volctl_shifter.sv
module volctl_shifter #(
   parameter int unsigned FRAME_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               shift,
   input  logic               din,
   output logic [FRAME_W-1:0] frame,
   output logic               full
);

   // counter saturates one past a full frame so over-long frames stay invalid
   localparam int unsigned CAP   = FRAME_W + 1;
   localparam int unsigned CNT_W = $clog2(CAP + 1);

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("volctl_shifter: FRAME_W too small");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         frame <= '0;
      end else if (!en) begin
         cnt <= '0;
      end else if (shift) begin
         frame <= {din, frame[FRAME_W-1:1]};
         if (cnt != CNT_W'(CAP)) cnt <= cnt + 1'b1;
      end
   end

   assign full = (cnt == CNT_W'(FRAME_W));

   a_r4_cnt_capped: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(CAP));

   a_r10_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(frame));

endmodule

// File: rtl/volctl_chan_dec.sv
module volctl_chan_dec #(
   parameter int unsigned CODE_W   = 6,
   parameter int unsigned COARSE_N = 7,
   parameter int unsigned FINE_N   = 5
) (
   input  logic [CODE_W-1:0]   code,
   output logic [COARSE_N-1:0] coarse,
   output logic [FINE_N-1:0]   fine,
   output logic                cut
);

   localparam int unsigned CUT_CODE = COARSE_N * FINE_N;

   generate
      if (CUT_CODE >= (1 << CODE_W)) begin : g_bad_code_w
         $error("volctl_chan_dec: CODE_W cannot hold the cut code");
      end
   endgenerate

   // coarse tap k covers codes [k*FINE_N, (k+1)*FINE_N)
   for (genvar k = 0; k < COARSE_N; k++) begin : g_coarse
      localparam logic [CODE_W-1:0] LO = CODE_W'(k * FINE_N);
      localparam logic [CODE_W-1:0] HI = CODE_W'((k + 1) * FINE_N);
      assign coarse[k] = (code >= LO) && (code < HI);
   end

   // fine tap j is hit by every code with remainder j below the cut code
   for (genvar j = 0; j < FINE_N; j++) begin : g_fine
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int k = 0; k < COARSE_N; k++) begin
            if (code == CODE_W'(k * FINE_N + j)) hit = 1'b1;
         end
      end
      assign fine[j] = hit;
   end

   assign cut = (code >= CODE_W'(CUT_CODE));

endmodule

// File: rtl/volctl_serial_if.sv
module volctl_serial_if
   import volctl_pkg::*;
#(
   parameter int unsigned ADDR_W      = VC_ADDR_W,
   parameter int unsigned CODE_W      = VC_CODE_W,
   parameter int unsigned COARSE_N    = VC_COARSE_N,
   parameter int unsigned FINE_N      = VC_FINE_N,
   parameter int unsigned ADDR_HI     = 88,
   parameter int unsigned ADDR_LO     = 89,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_cs,
   input  logic                ser_clk,
   input  logic                ser_dat,
   input  logic                addr_sel,
   output logic [COARSE_N-1:0] l_coarse,
   output logic [FINE_N-1:0]   l_fine,
   output logic                l_cut,
   output logic [COARSE_N-1:0] r_coarse,
   output logic [FINE_N-1:0]   r_fine,
   output logic                r_cut,
   output logic                mute
);

   localparam int unsigned N_CH     = 2;
   localparam int unsigned CTRL_W   = N_CH * CODE_W;
   localparam int unsigned FRAME_W  = ADDR_W + CTRL_W;
   localparam int unsigned CUT_CODE = COARSE_N * FINE_N;

   generate
      if (ADDR_HI >= (1 << ADDR_W) || ADDR_LO >= (1 << ADDR_W)) begin : g_bad_addr
         $error("volctl_serial_if: address codes exceed ADDR_W");
      end
      if (ADDR_HI == ADDR_LO) begin : g_same_addr
         $error("volctl_serial_if: strap addresses must differ");
      end
   endgenerate

   vc_pins_t           raw, pins;
   logic               cs_fall, sck_rise;
   logic [FRAME_W-1:0] frame;
   logic               full, match, commit;

   assign raw = {ser_cs, ser_clk, ser_dat};

   volctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins_i   (raw),
      .pins_o   (pins),
      .cs_fall  (cs_fall),
      .sck_rise (sck_rise)
   );

   volctl_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (pins.cs),
      .shift (sck_rise),
      .din   (pins.sd),
      .frame (frame),
      .full  (full)
   );

   assign match  = frame[ADDR_W-1:0] ==
                   (addr_sel ? ADDR_W'(ADDR_HI) : ADDR_W'(ADDR_LO));
   assign commit = cs_fall & full & match;

   logic [N_CH-1:0][CODE_W-1:0] code_q;
   logic                        mute_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= {N_CH{CODE_W'(CUT_CODE)}};
         mute_q <= 1'b1;
      end else if (commit) begin
         code_q <= frame[FRAME_W-1:ADDR_W];
         mute_q <= 1'b0;
      end
   end

   assign mute = mute_q;

   logic [COARSE_N-1:0] coarse_w [N_CH];
   logic [FINE_N-1:0]   fine_w   [N_CH];
   logic                cut_w    [N_CH];

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
      volctl_chan_dec #(
         .CODE_W   (CODE_W),
         .COARSE_N (COARSE_N),
         .FINE_N   (FINE_N)
      ) u_dec (
         .code   (code_q[ch]),
         .coarse (coarse_w[ch]),
         .fine   (fine_w[ch]),
         .cut    (cut_w[ch])
      );

      a_r6_cut_clears_taps: assert property (@(posedge clk) disable iff (!rst_n)
         cut_w[ch] |-> (coarse_w[ch] == '0) && (fine_w[ch] == '0));

      a_r5_one_tap_each: assert property (@(posedge clk) disable iff (!rst_n)
         !cut_w[ch] |-> ($countones(coarse_w[ch]) == 1) && ($countones(fine_w[ch]) == 1));
   end

   assign l_coarse = coarse_w[0];
   assign l_fine   = fine_w[0];
   assign l_cut    = cut_w[0];
   assign r_coarse = coarse_w[1];
   assign r_fine   = fine_w[1];
   assign r_cut    = cut_w[1];

   a_r8_mute_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !mute |=> !mute);

   a_r8_mute_release_on_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mute) |-> $past(cs_fall));

   a_r3_settings_move_on_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_q) |-> $past(cs_fall));

endmodule

// File: tb/tb_volctl_serial_if.sv
`timescale 1ns/1ps
module tb_volctl_serial_if;

   localparam int SYNC = 2;
   localparam int H    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_cs = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, addr_sel = 1'b1;
   logic [6:0] l_coarse, r_coarse;
   logic [4:0] l_fine, r_fine;
   logic l_cut, r_cut, mute;

   always #2.5 clk = ~clk;

   volctl_serial_if #(.SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .ser_cs(ser_cs), .ser_clk(ser_clk),
      .ser_dat(ser_dat), .addr_sel(addr_sel),
      .l_coarse(l_coarse), .l_fine(l_fine), .l_cut(l_cut),
      .r_coarse(r_coarse), .r_fine(r_fine), .r_cut(r_cut), .mute(mute)
   );

   int total = 0, bad = 0;
   int exp_l = 35, exp_r = 35;
   logic exp_mute = 1'b1;

   function automatic logic [6:0] f_coarse(int c);
      return (c < 35) ? 7'(1 << (c / 5)) : 7'd0;
   endfunction
   function automatic logic [4:0] f_fine(int c);
      return (c < 35) ? 5'(1 << (c % 5)) : 5'd0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic check_state(input string tag);
      chk({tag, " mute"},     32'(mute),     32'(exp_mute));
      chk({tag, " l_coarse"}, 32'(l_coarse), 32'(f_coarse(exp_l)));
      chk({tag, " l_fine"},   32'(l_fine),   32'(f_fine(exp_l)));
      chk({tag, " l_cut"},    32'(l_cut),    32'(exp_l >= 35));
      chk({tag, " r_coarse"}, 32'(r_coarse), 32'(f_coarse(exp_r)));
      chk({tag, " r_fine"},   32'(r_fine),   32'(f_fine(exp_r)));
      chk({tag, " r_cut"},    32'(r_cut),    32'(exp_r >= 35));
   endtask

   // behavioural reference: pin history delayed by the synchroniser depth
   logic [2:0] hq[$];
   int         m_cnt, m_l = 35, m_r = 35;
   logic       m_mute = 1'b1;
   logic [19:0] m_word;

   always @(posedge clk) begin
      if (!rst_n) begin
         hq.delete();
         repeat (SYNC + 1) hq.push_back(3'b000);
         m_cnt = 0; m_l = 35; m_r = 35; m_mute = 1'b1; m_word = '0;
      end else begin
         logic [2:0] cur, prv;
         hq.push_back({ser_cs, ser_clk, ser_dat});
         prv = hq[0];
         cur = hq[1];
         void'(hq.pop_front());
         if (prv[2] && !cur[2]) begin
            if (m_cnt == 20 && m_word[7:0] == (addr_sel ? 8'd88 : 8'd89)) begin
               m_l = int'(m_word[13:8]);
               m_r = int'(m_word[19:14]);
               m_mute = 1'b0;
            end
         end
         if (!cur[2]) m_cnt = 0;
         else if (cur[1] && !prv[1]) begin
            if (m_cnt < 20) m_word[m_cnt] = cur[0];
            m_cnt++;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R8 model mute",   32'(mute), 32'(m_mute));
         chk("R5 model left",   {l_cut, l_fine, l_coarse}, {m_l >= 35, f_fine(m_l), f_coarse(m_l)});
         chk("R7 model right",  {r_cut, r_fine, r_coarse}, {m_r >= 35, f_fine(m_r), f_coarse(m_r)});
      end
   end

   function automatic logic [31:0] mk(int addr, int l, int r);
      return {12'd0, 6'(r), 6'(l), 8'(addr)};
   endfunction

   task automatic shift_bits(input int n, input logic [31:0] w);
      ser_cs = 1'b1;
      repeat (H) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         ser_dat = w[i];
         repeat (H) @(negedge clk);
         ser_clk = 1'b1;
         repeat (H) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (H) @(negedge clk);
   endtask

   task automatic end_frame();
      ser_cs = 1'b0;
      repeat (H + SYNC + 4) @(negedge clk);
   endtask

   task automatic send(input int n, input logic [31:0] w);
      shift_bits(n, w);
      end_frame();
   endtask

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=running exp=done");
      finish_up();
   end

   initial begin
      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check_state("R9 R8 reset");

      // R10: clock edges with enable low
      for (int i = 0; i < 6; i++) begin
         ser_dat = i[0];
         repeat (H) @(negedge clk); ser_clk = 1'b1;
         repeat (H) @(negedge clk); ser_clk = 0;
      end
      repeat (8) @(negedge clk);
      check_state("R10 idle clocks");

      // R2/R8: wrong address before any accepted frame
      send(20, mk(89, 3, 4));
      check_state("R2 R8 wrong addr");
      // R4 short frame before first valid
      send(19, mk(88, 3, 4));
      check_state("R4 R8 short");

      // R1 R5 R7 R10: first accepted frame
      send(20, mk(88, 0, 34));
      exp_l = 0; exp_r = 34; exp_mute = 1'b0;
      check_state("R1 R10 first frame");

      // R3: full frame shifted, enable still high
      shift_bits(20, mk(88, 12, 7));
      check_state("R3 before cs fall");
      end_frame();
      exp_l = 12; exp_r = 7;
      check_state("R3 after cs fall");

      // R4 short and long frames
      send(19, mk(88, 1, 2));
      check_state("R4 19 bits");
      send(21, mk(88, 1, 2) | 32'h0010_0000);
      check_state("R4 21 bits");

      // R2 strap low
      addr_sel = 1'b0;
      repeat (4) @(negedge clk);
      send(20, mk(89, 5, 29));
      exp_l = 5; exp_r = 29;
      check_state("R2 strap low 89");
      send(20, mk(88, 9, 9));
      check_state("R2 strap low 88 ignored");
      send(20, mk(200, 9, 9));
      check_state("R2 other addr");

      // R6 cut codes
      send(20, mk(89, 35, 63));
      exp_l = 35; exp_r = 63;
      check_state("R6 cut 35/63");
      send(20, mk(89, 40, 9));
      exp_l = 40; exp_r = 9;
      check_state("R6 R7 cut 40 / 9");
      chk("R8 mute sticky", 32'(mute), 32'd0);

      // R5 R7 sweep all steps
      addr_sel = 1'b1;
      repeat (4) @(negedge clk);
      for (int c = 0; c < 35; c++) begin
         send(20, mk(88, c, 34 - c));
         exp_l = c; exp_r = 34 - c;
         check_state("R5 R7 sweep");
      end

      finish_up();
   end

endmodule